// File: doc/BRIEF.md
# I2S Slave Receiver

This block receives stereo serial audio over an I2S-style three-wire link and turns each frame into a pair of parallel channel words. It is a pure slave: the bit clock and the word strobe come from the local transmit side of the same audio port, and the receiver only samples them. All three link wires are brought into the core clock domain through synchronizers. A bit is captured on the selected edge of the oversampled bit clock.

Four run-time configuration inputs select the slot width (16 or 32 bits), the word-strobe polarity, the capture edge of the bit clock, and the data alignment. In delayed alignment the most significant bit arrives one bit clock after the strobe transition. In aligned mode it arrives on the same bit clock as the transition. Words are taken most significant bit first. Once the right word of a frame is complete, the block presents both channel words together with a one-cycle valid strobe. Configuration is sampled continuously while no word has yet started. After that it is only taken at the start of a left word, so a change never splits a frame.

Top module: `i2s_slave_rx`

## Requirements
- R1: After reset `smp_valid` is 0 and `smp_left` and `smp_right` are all zeros.
- R2: Words are assembled most significant bit first. With normal strobe polarity the left word is carried while the word strobe is low and the right word while it is high. Once the right word's last bit is captured after a complete left word, `smp_valid` is high for exactly one clock cycle, with both words on `smp_left` and `smp_right`. One frame gives exactly one pulse.
- R3: With `cfg_wide` = 0 a word is 16 bits. It appears in bits [15:0] of the outputs, and bits [31:16] are zero.
- R4: With `cfg_wide` = 1 a word is 32 bits and fills the whole output.
- R5: With `cfg_ws_inv` = 1 the strobe meaning is swapped: the left word is carried while the strobe is high.
- R6: With `cfg_sck_inv` = 0 bits are captured on the rising edge of `sck_in`. With `cfg_sck_inv` = 1 they are captured on the falling edge.
- R7: With `cfg_no_delay` = 0 the first data bit follows one capture edge after the strobe transition. With `cfg_no_delay` = 1 the first data bit is captured on the same edge at which the strobe transition is seen.
- R8: Until the first word starts after reset, the configuration inputs take effect directly. After that, a change is adopted only at the start of a left word. Changing `cfg_wide` in the middle of a frame leaves that frame decoded with the old width.
- R9: A right word that was not preceded by a complete left word since the last valid strobe produces no valid strobe.
- R10: When a slot is longer than the configured word width, only the first bits of the slot (the most significant ones) are kept. The remaining bits of the slot are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sck_in | input | 1 | Bit clock from the transmit side |
| ws_in | input | 1 | Word strobe from the transmit side |
| sd_in | input | 1 | Serial data |
| cfg_wide | input | 1 | 1: 32-bit words, 0: 16-bit words |
| cfg_no_delay | input | 1 | 1: data starts on the strobe transition, 0: one bit later |
| cfg_ws_inv | input | 1 | 1: inverted word strobe polarity |
| cfg_sck_inv | input | 1 | 1: capture on falling bit-clock edge |
| smp_valid | output | 1 | One-cycle strobe marking a fresh stereo pair |
| smp_left | output | 32 | Left channel word |
| smp_right | output | 32 | Right channel word |

## Verification
A wrong internal state shows up at the ports within one frame, in one of three ways. A corrupted bit counter or alignment flag shifts every later word by one or more bit positions. A wrong channel tag swaps the two words or suppresses the valid strobe for that frame. A configuration register loaded at the wrong moment changes the width or bit order of the frame in which the change was made. The bench therefore compares every delivered pair, and the number of pairs, against words it computes for each combination of width, polarity, edge and alignment.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  // Link configuration as held by the receiver
  typedef struct packed {
    logic wide;      // 1: long slot width, 0: short slot width
    logic no_delay;  // 1: first bit on strobe transition
    logic ws_inv;    // 1: strobe high marks the left channel
    logic sck_inv;   // 1: capture on falling bit-clock edge
  } rx_cfg_t;

  localparam logic CH_LEFT  = 1'b0;
  localparam logic CH_RIGHT = 1'b1;

endpackage

// File: rtl/i2s_rx_sync.sv
module i2s_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_comb stage_d[s] = d_i;
    end else begin : g_next
      always_comb stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_d[s];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/i2s_rx_edge.sv
module i2s_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic inv_i,
  output logic cap_o
);

  logic sck_d_q;
  logic cur_eff;
  logic old_eff;

  always_comb begin
    cur_eff = sck_i ^ inv_i;
    old_eff = sck_d_q ^ inv_i;
    cap_o   = cur_eff & ~old_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d_q <= 1'b0;
    else        sck_d_q <= sck_i;
  end

endmodule

// File: rtl/i2s_rx_framer.sv
module i2s_rx_framer
  import i2s_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cap_i,
  input  logic    ws_i,
  input  rx_cfg_t cfg_in,
  output logic    start_o,
  output logic    start_ch_o,
  output rx_cfg_t cfg_o
);

  logic    prev_ws_q, prev_ws_d;
  logic    have_prev_q, have_prev_d;
  logic    pend_q, pend_d;
  logic    synced_q, synced_d;
  rx_cfg_t cfg_q, cfg_d;
  logic    ws_change;
  logic    start_left;

  always_comb begin
    ws_change   = cap_i & have_prev_q & (ws_i != prev_ws_q);
    start_ch_o  = ws_i ^ cfg_q.ws_inv;
    start_o     = cfg_q.no_delay ? ws_change : (cap_i & pend_q);
    start_left  = start_o & (start_ch_o == CH_LEFT);

    prev_ws_d   = prev_ws_q;
    have_prev_d = have_prev_q;
    pend_d      = pend_q;
    if (cap_i) begin
      prev_ws_d   = ws_i;
      have_prev_d = 1'b1;
      pend_d      = ws_change;
    end

    synced_d = synced_q | start_o;
    cfg_d    = (!synced_q || start_left) ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ws_q   <= 1'b0;
      have_prev_q <= 1'b0;
      pend_q      <= 1'b0;
      synced_q    <= 1'b0;
      cfg_q       <= '0;
    end else begin
      prev_ws_q   <= prev_ws_d;
      have_prev_q <= have_prev_d;
      pend_q      <= pend_d;
      synced_q    <= synced_d;
      cfg_q       <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (synced_q && !cap_i) |=> $stable(cfg_q));

endmodule

// File: rtl/i2s_rx_shifter.sv
module i2s_rx_shifter #(
  parameter int SLOT_MAX = 32,
  parameter int SLOT_MIN = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_i,
  input  logic                sd_i,
  input  logic                start_i,
  input  logic                start_ch_i,
  input  logic                wide_i,
  output logic                done_o,
  output logic                done_ch_o,
  output logic [SLOT_MAX-1:0] word_o
);

  localparam int CW = $clog2(SLOT_MAX + 1);

  logic [SLOT_MAX-1:0] shift_q, shift_d;
  logic [CW-1:0]       cnt_q, cnt_d;
  logic                ch_q, ch_d;
  logic                active_q, active_d;
  logic                done_q, done_d;
  logic                dch_q, dch_d;
  logic [SLOT_MAX-1:0] word_q, word_d;
  logic [CW-1:0]       width_cur;
  logic [CW-1:0]       cnt_inc;

  always_comb begin
    width_cur = wide_i ? CW'(SLOT_MAX) : CW'(SLOT_MIN);
    cnt_inc   = cnt_q + CW'(1);

    shift_d  = shift_q;
    cnt_d    = cnt_q;
    ch_d     = ch_q;
    active_d = active_q;
    done_d   = 1'b0;
    dch_d    = dch_q;
    word_d   = word_q;

    if (cap_i) begin
      if (start_i) begin
        shift_d  = {{(SLOT_MAX-1){1'b0}}, sd_i};
        cnt_d    = CW'(1);
        ch_d     = start_ch_i;
        active_d = 1'b1;
      end else if (active_q && (cnt_q < width_cur)) begin
        shift_d = {shift_q[SLOT_MAX-2:0], sd_i};
        cnt_d   = cnt_inc;
        if (cnt_inc == width_cur) begin
          done_d = 1'b1;
          dch_d  = ch_q;
          word_d = shift_d;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      cnt_q    <= '0;
      ch_q     <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      dch_q    <= 1'b0;
      word_q   <= '0;
    end else begin
      shift_q  <= shift_d;
      cnt_q    <= cnt_d;
      ch_q     <= ch_d;
      active_q <= active_d;
      done_q   <= done_d;
      dch_q    <= dch_d;
      word_q   <= word_d;
    end
  end

  assign done_o    = done_q;
  assign done_ch_o = dch_q;
  assign word_o    = word_q;

  // R10
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= width_cur);

  // R6
  done_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(cap_i));

endmodule

// File: rtl/i2s_slave_rx.sv
module i2s_slave_rx
  import i2s_rx_pkg::*;
#(
  parameter int SLOT_MAX    = 32,
  parameter int SLOT_MIN    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_in,
  input  logic                ws_in,
  input  logic                sd_in,
  input  logic                cfg_wide,
  input  logic                cfg_no_delay,
  input  logic                cfg_ws_inv,
  input  logic                cfg_sck_inv,
  output logic                smp_valid,
  output logic [SLOT_MAX-1:0] smp_left,
  output logic [SLOT_MAX-1:0] smp_right
);

  localparam int PIN_W = 3;

  logic [1:0]          rst_pipe_q;
  logic                rst_n_int;
  logic [PIN_W-1:0]    pin_s;
  logic                cap;
  rx_cfg_t             cfg_req;
  rx_cfg_t             cfg_cur;
  logic                start;
  logic                start_ch;
  logic                done;
  logic                done_ch;
  logic [SLOT_MAX-1:0] word;

  logic [SLOT_MAX-1:0] hold_q, hold_d;
  logic                left_ok_q, left_ok_d;
  logic                valid_q, valid_d;
  logic [SLOT_MAX-1:0] left_q, left_d;
  logic [SLOT_MAX-1:0] right_q, right_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  i2s_rx_sync #(
    .WIDTH (PIN_W),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n_int),
    .d_i  ({sck_in, ws_in, sd_in}),
    .q_o  (pin_s)
  );

  i2s_rx_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n_int),
    .sck_i(pin_s[2]),
    .inv_i(cfg_cur.sck_inv),
    .cap_o(cap)
  );

  always_comb begin
    cfg_req.wide     = cfg_wide;
    cfg_req.no_delay = cfg_no_delay;
    cfg_req.ws_inv   = cfg_ws_inv;
    cfg_req.sck_inv  = cfg_sck_inv;
  end

  i2s_rx_framer u_framer (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cap_i     (cap),
    .ws_i      (pin_s[1]),
    .cfg_in    (cfg_req),
    .start_o   (start),
    .start_ch_o(start_ch),
    .cfg_o     (cfg_cur)
  );

  i2s_rx_shifter #(
    .SLOT_MAX(SLOT_MAX),
    .SLOT_MIN(SLOT_MIN)
  ) u_shifter (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cap_i     (cap),
    .sd_i      (pin_s[0]),
    .start_i   (start),
    .start_ch_i(start_ch),
    .wide_i    (cfg_cur.wide),
    .done_o    (done),
    .done_ch_o (done_ch),
    .word_o    (word)
  );

  // pair a finished left word with the following right word
  always_comb begin
    hold_d    = hold_q;
    left_ok_d = left_ok_q;
    valid_d   = 1'b0;
    left_d    = left_q;
    right_d   = right_q;
    if (done) begin
      if (done_ch == CH_LEFT) begin
        hold_d    = word;
        left_ok_d = 1'b1;
      end else if (left_ok_q) begin
        left_d    = hold_q;
        right_d   = word;
        valid_d   = 1'b1;
        left_ok_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      hold_q    <= '0;
      left_ok_q <= 1'b0;
      valid_q   <= 1'b0;
      left_q    <= '0;
      right_q   <= '0;
    end else begin
      hold_q    <= hold_d;
      left_ok_q <= left_ok_d;
      valid_q   <= valid_d;
      left_q    <= left_d;
      right_q   <= right_d;
    end
  end

  assign smp_valid = valid_q;
  assign smp_left  = left_q;
  assign smp_right = right_q;

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    smp_valid |=> !smp_valid);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (smp_valid && !cfg_cur.wide) |->
      (smp_left[SLOT_MAX-1:SLOT_MIN] == '0 && smp_right[SLOT_MAX-1:SLOT_MIN] == '0));

endmodule

// File: tb/i2s_slave_rx_bench.sv
`timescale 1ns/1ps
module i2s_slave_rx_bench;

  logic        clk;
  logic        rst_n;
  logic        sck, ws, sd;
  logic        b_wide, b_nd, b_wsi, b_ski;
  logic        valid;
  logic [31:0] left, right;

  int          total;
  int          bad;
  int          n_got;
  logic        dbl;
  logic        prev_v;
  logic [31:0] got_l [8];
  logic [31:0] got_r [8];
  logic [31:0] exp_l [8];
  logic [31:0] exp_r [8];
  int          exp_n;
  logic        last_lsb;

  i2s_slave_rx u_i2s_slave_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_in      (sck),
    .ws_in       (ws),
    .sd_in       (sd),
    .cfg_wide    (b_wide),
    .cfg_no_delay(b_nd),
    .cfg_ws_inv  (b_wsi),
    .cfg_sck_inv (b_ski),
    .smp_valid   (valid),
    .smp_left    (left),
    .smp_right   (right)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      n_got  = 0;
      dbl    = 1'b0;
      prev_v = 1'b0;
    end else begin
      if (valid) begin
        if (n_got < 8) begin
          got_l[n_got] = left;
          got_r[n_got] = right;
        end
        n_got = n_got + 1;
        if (prev_v) dbl = 1'b1;
      end
      prev_v = valid;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] extract(input logic [31:0] w, input int slot, input int cw);
    logic [31:0] m;
    m = (slot == 32) ? 32'hFFFF_FFFF : ((32'd1 << slot) - 32'd1);
    return (w & m) >> (slot - cw);
  endfunction

  task automatic bit_slot(input logic wse, input logic d);
    @(negedge clk);
    sck = b_ski;
    ws  = wse ^ b_wsi;
    sd  = d;
    repeat (4) @(negedge clk);
    sck = ~b_ski;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(input logic wse, input logic [31:0] word,
                           input int slot, input int flip_at);
    for (int i = 0; i < slot; i++) begin
      logic b;
      if (b_nd) b = word[slot-1-i];
      else      b = (i == 0) ? last_lsb : word[slot-i];
      if (i == flip_at) b_wide = 1'b1;
      bit_slot(wse, b);
    end
    last_lsb = word[0];
  endtask

  task automatic start_group(input logic w, input logic nd, input logic wi, input logic si);
    rst_n  = 1'b0;
    b_wide = w;
    b_nd   = nd;
    b_wsi  = wi;
    b_ski  = si;
    sck    = si;
    ws     = 1'b1 ^ wi;
    sd     = 1'b0;
    repeat (4) @(negedge clk);
    rst_n  = 1'b1;
    repeat (4) @(negedge clk);
    exp_n    = 0;
    last_lsb = 1'b0;
  endtask

  task automatic frame(input logic [31:0] lw, input logic [31:0] rw,
                       input int slot, input int cw, input int flip_at);
    send_half(1'b0, lw, slot, flip_at);
    send_half(1'b1, rw, slot, -1);
    exp_l[exp_n] = extract(lw, slot, cw);
    exp_r[exp_n] = extract(rw, slot, cw);
    exp_n = exp_n + 1;
  endtask

  task automatic trailer();
    bit_slot(1'b0, last_lsb);
    bit_slot(1'b0, 1'b0);
    repeat (10) @(negedge clk);
  endtask

  task automatic end_group(input string tag);
    check(n_got == exp_n, "R2", 32'(n_got), 32'(exp_n));
    check(!dbl, "R2", 32'(dbl), 32'd0);
    for (int k = 0; k < exp_n && k < 8 && k < n_got; k++) begin
      check(got_l[k] === exp_l[k], tag, got_l[k], exp_l[k]);
      check(got_r[k] === exp_r[k], tag, got_r[k], exp_r[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total = total + 1;
    bad   = bad + 1;
    $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0;
    bad   = 0;

    // full sweep of width, alignment, strobe polarity and capture edge
    for (int g = 0; g < 16; g++) begin
      logic        w, nd, wi, si;
      int          slot;
      string       tag;
      w  = g[0];
      nd = g[1];
      wi = g[2];
      si = g[3];
      slot = w ? 32 : 16;
      if (wi)      tag = "R5";
      else if (si) tag = "R6";
      else if (nd) tag = "R7";
      else if (w)  tag = "R4";
      else         tag = "R3";
      start_group(w, nd, wi, si);
      if (g == 0) begin
        check(valid == 1'b0, "R1", 32'(valid), 32'd0);
        check(left == 32'd0, "R1", left, 32'd0);
        check(right == 32'd0, "R1", right, 32'd0);
      end
      for (int k = 0; k < 4; k++) bit_slot(1'b1, 1'b0);
      for (int k = 0; k < 3; k++) begin
        logic [31:0] lw, rw;
        lw = 32'h9E37_79B9 * 32'(g * 5 + k + 1);
        rw = ~lw ^ {lw[15:0], lw[31:16]};
        frame(lw, rw, slot, slot, -1);
      end
      trailer();
      end_group(tag);
    end

    // R8: width change in the middle of a left word waits for the next frame
    start_group(1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) bit_slot(1'b1, 1'b0);
    frame(32'h0000_B38E, 32'h0000_4C71, 16, 16, 5);
    frame(32'hC0DE_1234, 32'h8765_FEED, 32, 32, -1);
    frame(32'h0F1E_2D3C, 32'hF0E1_D2C3, 32, 32, -1);
    trailer();
    end_group("R8");

    // R9: a lone right word at the start gives no pair
    start_group(1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) bit_slot(1'b0, 1'b0);
    send_half(1'b1, 32'hDEAD_BEEF, 32, -1);
    frame(32'h1357_9BDF, 32'h2468_ACE0, 32, 32, -1);
    frame(32'hAAAA_5555, 32'h5555_AAAA, 32, 32, -1);
    trailer();
    end_group("R9");

    // R10: long slots with short words keep the leading bits
    for (int nd = 0; nd < 2; nd++) begin
      start_group(1'b0, nd[0], 1'b0, 1'b0);
      for (int k = 0; k < 4; k++) bit_slot(1'b1, 1'b0);
      frame(32'hA1B2_C3D4, 32'h1F2E_3D4C, 32, 16, -1);
      frame(32'h7001_8FFE, 32'hFFFF_0001, 32, 16, -1);
      trailer();
      end_group("R10");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule